// File: doc/BRIEF.md
# Reset Pin Qualifier with Watchdog Reset Drive-Out

This block turns a reset pin into the chip's internal reset and also drives that pin after a watchdog timeout. The pin reaches the block as an already synchronized level. It only causes a reset after it has stayed high for two whole machine cycles, so short glitches are filtered out. Once the pin has qualified, the internal reset follows it and ends on the first clock edge that sees the pin low.

A watchdog expiry pulse opens a fixed window of oscillator periods. For that whole window the internal reset is held asserted. While the window is open the block can also drive the pin high, so that other devices on the board are reset too. A local disable bit suppresses this drive. It can be written through a simple write strobe, and any internal reset clears it.

The block runs on the oscillator clock. An asynchronous power-on clear puts all of its state into a known condition.

Top module: `rst_pin_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_int`, `rst_pin_oe` and `rst_pin_out` are all 0. Just after `por_n` is released with the pin low, all three are still 0.
- R2: After the pin is sampled high on 24 consecutive clock edges (2 machine cycles of 12 periods each), `rst_int` is 1. After 23 such samples it is still 0.
- R3: A single low sample of the pin restarts qualification. A further 24 consecutive high samples are then needed before `rst_int` asserts.
- R4: Once the pin has qualified, `rst_int` stays 1 while the pin stays high. It returns to 0 on the first clock edge that samples the pin low, provided no watchdog window is open.
- R5: A `wdt_expire` pulse sampled at an edge opens a window of exactly 96 clock periods, starting at that edge. For the whole window `rst_int` is 1. When the disable bit is 0, `rst_pin_oe` is also 1 for the whole window. `rst_pin_out` is 1 exactly when `rst_pin_oe` is 1.
- R6: If the disable bit is 1 when a window opens, `rst_int` is still asserted for the 96 periods, but `rst_pin_oe` stays 0 for the whole window.
- R7: A `wdt_expire` pulse that arrives while a window is open restarts the 96-period count, so the window ends 96 periods after the latest pulse. Whether the pin is driven is decided only when the window first opens.
- R8: Any internal reset clears the disable bit to 0, which is its default. A write that arrives while `rst_int` is 1 is ignored.
- R9: When `rst_int` is 0, a `cfg_we` pulse loads `cfg_dis_wdata` into the disable bit. The value takes effect for the next window that opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin_in | input | 1 | Synchronized level read back from the reset pad |
| wdt_expire | input | 1 | One-cycle watchdog timeout pulse |
| cfg_we | input | 1 | Write strobe for the drive-out disable bit |
| cfg_dis_wdata | input | 1 | New value of the disable bit (1 = no pin drive) |
| rst_int | output | 1 | Internal reset, active high |
| rst_pin_oe | output | 1 | Output enable for the reset pad |
| rst_pin_out | output | 1 | Value driven onto the reset pad while enabled |

## Verification
The hardest cases to reach are the ones where the block's own pin drive feeds back into its own qualifier. The same hard group includes a disable bit that is cleared by the very reset it suppressed, and a watchdog retrigger that lands inside an open window. The bench models the pad as a wire-OR of the drive and an external level, so the driven high is read back on the pin. Directed sequences set the disable bit, fire a timeout and then retrigger it mid-window. Random runs then mix pin pulses of varied lengths with sparse timeouts and writes. Throughout, a reference model computed from the requirements is compared against the outputs every cycle.

// File: rtl/rst_pin_pkg.sv
package rst_pin_pkg;

  // Total oscillator periods the pin must stay high before it qualifies.
  function automatic int unsigned qual_periods(int unsigned per_mc, int unsigned n_mc);
    return per_mc * n_mc;
  endfunction

  // Bits needed for a counter that must reach maxv.
  function automatic int unsigned cnt_bits(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int unsigned LIMIT = 24,
  parameter int unsigned W     = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_in,
  output logic qual_done
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] hi_run;

  // Count consecutive high samples, saturating at the limit.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               hi_run <= '0;
    else if (!pin_in)         hi_run <= '0;
    else if (hi_run != LIM)   hi_run <= hi_run + 1'b1;
  end

  assign qual_done = (hi_run == LIM);
endmodule

// File: rtl/rst_wdt_window.sv
module rst_wdt_window #(
  parameter int unsigned SPAN = 96,
  parameter int unsigned W    = 7
) (
  input  logic clk,
  input  logic por_n,
  input  logic expire,
  input  logic dis_in,
  output logic win_active,
  output logic win_load,
  output logic drive_sel
);
  localparam logic [W-1:0] SPAN_V = W'(SPAN);

  logic [W-1:0] remain;

  assign win_load   = expire;
  assign win_active = (remain != '0);

  // Window countdown; a new pulse always reloads the full span.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           remain <= '0;
    else if (win_load)    remain <= SPAN_V;
    else if (win_active)  remain <= remain - 1'b1;
  end

  // The drive choice is taken only when a window opens from idle.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       drive_sel <= 1'b0;
    else if (win_load && !win_active) drive_sel <= ~dis_in;
  end
endmodule

// File: rtl/rst_dis_reg.sv
module rst_dis_reg (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic we,
  input  logic wdata,
  output logic dis_q
);
  // Reset has priority over writes.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    dis_q <= 1'b0;
    else if (clr)  dis_q <= 1'b0;
    else if (we)   dis_q <= wdata;
  end
endmodule

// File: rtl/rst_pin_ctrl.sv
module rst_pin_ctrl #(
  parameter int unsigned OSC_PER_MC  = 12,
  parameter int unsigned QUAL_MC     = 2,
  parameter int unsigned OUT_PERIODS = 96
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_in,
  input  logic wdt_expire,
  input  logic cfg_we,
  input  logic cfg_dis_wdata,
  output logic rst_int,
  output logic rst_pin_oe,
  output logic rst_pin_out
);
  import rst_pin_pkg::*;

  localparam int unsigned QUAL_LEN = qual_periods(OSC_PER_MC, QUAL_MC);
  localparam int unsigned QW       = cnt_bits(QUAL_LEN);
  localparam int unsigned WW       = cnt_bits(OUT_PERIODS);

  // Named internal events, used by the checker.
  logic qual_done;
  logic win_active;
  logic win_load;
  logic drive_sel;
  logic dis_q;

  rst_pin_qual #(.LIMIT(QUAL_LEN), .W(QW)) u_qual (
    .clk       (clk),
    .por_n     (por_n),
    .pin_in    (rst_pin_in),
    .qual_done (qual_done)
  );

  rst_wdt_window #(.SPAN(OUT_PERIODS), .W(WW)) u_win (
    .clk        (clk),
    .por_n      (por_n),
    .expire     (wdt_expire),
    .dis_in     (dis_q),
    .win_active (win_active),
    .win_load   (win_load),
    .drive_sel  (drive_sel)
  );

  rst_dis_reg u_dis (
    .clk   (clk),
    .por_n (por_n),
    .clr   (rst_int),
    .we    (cfg_we),
    .wdata (cfg_dis_wdata),
    .dis_q (dis_q)
  );

  assign rst_int     = qual_done | win_active;
  assign rst_pin_oe  = win_active & drive_sel;
  assign rst_pin_out = rst_pin_oe;
endmodule

// File: rtl/rst_pin_ctrl_chk.sv
module rst_pin_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic rst_pin_in,
  input logic wdt_expire,
  input logic rst_int,
  input logic rst_pin_oe,
  input logic qual_done,
  input logic win_active,
  input logic drive_sel,
  input logic dis_q
);
  a_r1_clear_in_por: assert property (@(posedge clk) !por_n |-> (!rst_int && !rst_pin_oe));

  a_r2_qual_after_high: assert property (@(posedge clk) disable iff (!por_n)
    $rose(qual_done) |-> $past(rst_pin_in));

  a_r3_low_restarts: assert property (@(posedge clk) disable iff (!por_n)
    !rst_pin_in |=> !qual_done);

  a_r4_release_on_low: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pin_in && !wdt_expire && !win_active) |=> !rst_int);

  a_r5_pulse_opens: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expire |=> (rst_int && win_active));

  a_r5_drive_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_pin_oe |-> rst_int);

  a_r6_disabled_no_drive: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_expire && !win_active && dis_q) |=> !rst_pin_oe);

  a_r7_retrigger_keeps_choice: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_expire && win_active) |=> $stable(drive_sel));

  a_r8_reset_clears_dis: assert property (@(posedge clk) disable iff (!por_n)
    rst_int |=> !dis_q);
endmodule

bind rst_pin_ctrl rst_pin_ctrl_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_pin_in (rst_pin_in),
  .wdt_expire (wdt_expire),
  .rst_int    (rst_int),
  .rst_pin_oe (rst_pin_oe),
  .qual_done  (qual_done),
  .win_active (win_active),
  .drive_sel  (drive_sel),
  .dis_q      (dis_q)
);

// File: tb/rst_pin_ctrl_bench.sv
module rst_pin_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QLEN = 24;
  localparam int WLEN = 96;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic por_n, ext_pin, wdt, we, wd;
  logic rst_int, oe, pout;
  wire  pad = oe ? pout : ext_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  rst_pin_ctrl u_rst_pin_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_in(pad), .wdt_expire(wdt),
    .cfg_we(we), .cfg_dis_wdata(wd),
    .rst_int(rst_int), .rst_pin_oe(oe), .rst_pin_out(pout)
  );

  // Reference model, written from the requirements.
  int m_cnt, m_win;
  bit m_sel, m_dis, m_oe;

  function automatic bit exp_rst(int cnt, int win);
    return (cnt >= QLEN) || (win > 0);
  endfunction

  function automatic int next_cnt(int cnt, bit p);
    if (!p) return 0;
    return (cnt < QLEN) ? cnt + 1 : cnt;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_cnt = 0; m_win = 0; m_sel = 0; m_dis = 0; m_oe = 0;
    end else begin
      bit p, rnow;
      p    = m_oe ? 1'b1 : ext_pin;
      rnow = exp_rst(m_cnt, m_win);
      m_cnt = next_cnt(m_cnt, p);
      if (wdt) begin
        if (m_win == 0) m_sel = !m_dis;
        m_win = WLEN;
      end else if (m_win > 0) m_win--;
      if (rnow) m_dis = 0; else if (we) m_dis = wd;
      m_oe = (m_win > 0) && m_sel;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare every cycle against the model.
  always @(negedge clk) if (por_n) begin
    chk({cur_tag, " rst"}, rst_int, exp_rst(m_cnt, m_win));
    chk({cur_tag, " oe"},  oe, m_oe);
    chk({cur_tag, " R5 out"}, pout, m_oe);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wdt();
    wdt = 1'b1; step(1); wdt = 1'b0;
  endtask

  task automatic write_dis(bit v);
    we = 1'b1; wd = v; step(1); we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 0; ext_pin = 0; wdt = 0; we = 0; wd = 0;
    step(3);
    chk("R1 por rst", rst_int, 1'b0);
    chk("R1 por oe", oe, 1'b0);
    chk("R1 por out", pout, 1'b0);
    por_n = 1; step(2);
    chk("R1 after por", rst_int, 1'b0);

    cur_tag = "R2"; ext_pin = 1; step(23);
    chk("R2 23 samples", rst_int, 1'b0);
    step(1);
    chk("R2 24 samples", rst_int, 1'b1);

    cur_tag = "R4"; step(10);
    chk("R4 held", rst_int, 1'b1);
    ext_pin = 0; step(1);
    chk("R4 release", rst_int, 1'b0);

    cur_tag = "R3"; ext_pin = 1; step(20); ext_pin = 0; step(1); ext_pin = 1;
    step(23);
    chk("R3 restart 23", rst_int, 1'b0);
    step(1);
    chk("R3 restart 24", rst_int, 1'b1);
    ext_pin = 0; step(3);

    cur_tag = "R5"; pulse_wdt();
    for (int i = 0; i < WLEN; i++) begin
      chk("R5 window oe", oe, 1'b1);
      chk("R5 window rst", rst_int, 1'b1);
      step(1);
    end
    chk("R5 window end oe", oe, 1'b0);
    chk("R4 pad still high", rst_int, 1'b1);
    step(1);
    chk("R4 after drive", rst_int, 1'b0);

    cur_tag = "R9"; write_dis(1'b1);
    cur_tag = "R6"; pulse_wdt();
    for (int i = 0; i < WLEN; i++) begin
      chk("R6 no drive", oe, 1'b0);
      chk("R6 rst held", rst_int, 1'b1);
      step(1);
    end
    chk("R6 end", rst_int, 1'b0);

    cur_tag = "R8"; pulse_wdt();
    chk("R8 dis cleared", oe, 1'b1);
    step(30); write_dis(1'b1);
    step(WLEN + 5);
    pulse_wdt();
    chk("R8 write in reset ignored", oe, 1'b1);

    cur_tag = "R7"; step(50); pulse_wdt();
    for (int i = 0; i < WLEN - 1; i++) step(1);
    chk("R7 extended", oe, 1'b1);
    step(3);
    write_dis(1'b1); pulse_wdt(); step(40); pulse_wdt();
    chk("R7 choice kept", oe, 1'b0);
    step(WLEN + 5);

    cur_tag = "R4 R5 random";
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 999));
      if (r < 40) ext_pin = ~ext_pin;
      wdt = (r >= 990);
      we  = (r >= 960 && r < 980);
      wd  = r[0];
      step(1);
    end
    wdt = 0; we = 0; ext_pin = 0; step(WLEN + 30);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h1234));
endmodule